// File: doc/BRIEF.md
# Descriptor Condition Evaluator

This unit makes the three control decisions of a descriptor-driven DMA channel for the descriptor the channel currently holds. The three decisions are whether to raise an interrupt, whether to jump to another descriptor and whether to stall on the present one. The parent channel pulses `eval_req` once the descriptor's data phase is done. It presents the descriptor's 6-bit control field, its 32-bit command-dependent word, the current command pointer and the channel's device-status bits. It also presents a mask/value pair for each decision, sliced from bits [19:16] and [3:0] of the matching select register.

Each decision has a 2-bit code: never, if the condition is true, if the condition is false, or always. The condition for a decision is a masked equality between the status bits and that decision's value field. All three decisions use the status sampled at the `eval_req` edge. One cycle after the edge, the registered outputs show the result. If the wait decision is true, the channel holds on the descriptor and nothing else changes. Otherwise the unit gives an advance pulse, an optional interrupt pulse, and the next command pointer with its branch-taken bit. The parent ORs `irq_pulse` with its own kill interrupt.

Top module: `dbc_eval_top`

## Requirements
- R1: During and right after reset, `irq_pulse`, `advance`, `wait_hold`, `branch_taken` and `next_ptr` are all zero.
- R2: A decision's condition is true when (status AND mask) equals (value AND mask). With a zero mask the condition is always true.
- R3: The interrupt code is `ctl_bits[5:4]`. It is 0 for never, 1 for condition true, 2 for condition false and 3 for always. When the decision is true and there is no wait, `irq_pulse` is high for exactly the one cycle after the `eval_req` edge.
- R4: The branch code is `ctl_bits[3:2]` and uses the same encoding as R3. A taken branch sets `next_ptr` to `cmd_dep` and `branch_taken` to 1.
- R5: When no branch is taken, `next_ptr` becomes `cur_ptr + 16` (modulo 2^32) and `branch_taken` becomes 0.
- R6: The wait code is `ctl_bits[1:0]` and uses the same encoding as R3. A true wait decision sets `wait_hold`. It suppresses `irq_pulse` and `advance`, and it leaves `next_ptr` and `branch_taken` unchanged.
- R7: All three decisions use the inputs sampled at the `eval_req` edge. Input changes while `eval_req` is low do not affect any output.
- R8: Every non-waiting evaluation produces a one-cycle `advance` pulse one cycle after its edge and clears `wait_hold`. Without `eval_req`, `irq_pulse` and `advance` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_req | input | 1 | Evaluate the held descriptor this cycle |
| ctl_bits | input | 6 | Interrupt [5:4], branch [3:2], wait [1:0] codes |
| dev_status | input | 4 | Device-status bits compared by all decisions |
| int_mask | input | 4 | Interrupt select mask |
| int_val | input | 4 | Interrupt select value |
| br_mask | input | 4 | Branch select mask |
| br_val | input | 4 | Branch select value |
| wait_mask | input | 4 | Wait select mask |
| wait_val | input | 4 | Wait select value |
| cur_ptr | input | 32 | Current command pointer |
| cmd_dep | input | 32 | Descriptor command-dependent word (branch target) |
| irq_pulse | output | 1 | One-cycle interrupt request |
| advance | output | 1 | One-cycle pulse: descriptor retired |
| wait_hold | output | 1 | Channel holds on the current descriptor |
| next_ptr | output | 32 | Next command pointer |
| branch_taken | output | 1 | Last retirement took a branch |

## Verification
The assertions check on every cycle that interrupts and advances appear only right after an evaluation edge, and that an interrupt never comes without an advance. They also check that a wait excludes both, that the pointer holds between retirements, and that it follows the branch target or the 16-byte step sampled at the edge. The code tables and the masked compare can only be shown by the bench's scenarios. These include each 2-bit code against true and false conditions, mask values of zero and all ones, and a status change between strobes.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  typedef enum logic [1:0] {
    DC_NEVER    = 2'd0,
    DC_IF_TRUE  = 2'd1,
    DC_IF_FALSE = 2'd2,
    DC_ALWAYS   = 2'd3
  } dcode_e;

  localparam int unsigned NUM_DEC = 3;
  localparam int unsigned DEC_IRQ = 0;
  localparam int unsigned DEC_BR  = 1;
  localparam int unsigned DEC_WT  = 2;
endpackage

// File: rtl/dbc_match.sv
module dbc_match #(
  parameter int unsigned STAT_W = 4
) (
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] mask,
  input  logic [STAT_W-1:0] value,
  output logic              hit
);
  always_comb begin
    hit = ((status & mask) == (value & mask));
  end
endmodule

// File: rtl/dbc_decide.sv
module dbc_decide
  import dbc_pkg::*;
(
  input  logic [1:0] code,
  input  logic       cond,
  output logic       decision
);
  dcode_e code_e;

  always_comb begin
    code_e = dcode_e'(code);
    unique case (code_e)
      DC_NEVER:    decision = 1'b0;
      DC_IF_TRUE:  decision = cond;
      DC_IF_FALSE: decision = ~cond;
      DC_ALWAYS:   decision = 1'b1;
      default:     decision = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbc_ptr_step.sv
module dbc_ptr_step #(
  parameter int unsigned PTR_W     = 32,
  parameter int unsigned DESC_BYTES = 16
) (
  input  logic [PTR_W-1:0] cur_ptr,
  input  logic [PTR_W-1:0] target,
  input  logic             take,
  output logic [PTR_W-1:0] nxt
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);

  always_comb begin
    if (take) nxt = target;
    else      nxt = cur_ptr + STEP;
  end
endmodule

// File: rtl/dbc_eval_top.sv
module dbc_eval_top
  import dbc_pkg::*;
#(
  parameter int unsigned PTR_W      = 32,
  parameter int unsigned STAT_W     = 4,
  parameter int unsigned DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_req,
  input  logic [5:0]        ctl_bits,
  input  logic [STAT_W-1:0] dev_status,
  input  logic [STAT_W-1:0] int_mask,
  input  logic [STAT_W-1:0] int_val,
  input  logic [STAT_W-1:0] br_mask,
  input  logic [STAT_W-1:0] br_val,
  input  logic [STAT_W-1:0] wait_mask,
  input  logic [STAT_W-1:0] wait_val,
  input  logic [PTR_W-1:0]  cur_ptr,
  input  logic [PTR_W-1:0]  cmd_dep,
  output logic              irq_pulse,
  output logic              advance,
  output logic              wait_hold,
  output logic [PTR_W-1:0]  next_ptr,
  output logic              branch_taken
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(DESC_BYTES);

  logic [STAT_W-1:0] sel_mask [NUM_DEC];
  logic [STAT_W-1:0] sel_val  [NUM_DEC];
  logic [1:0]        code     [NUM_DEC];
  logic [NUM_DEC-1:0] cond_hit;
  logic [NUM_DEC-1:0] dec;

  always_comb begin
    sel_mask[DEC_IRQ] = int_mask;  sel_val[DEC_IRQ] = int_val;
    sel_mask[DEC_BR]  = br_mask;   sel_val[DEC_BR]  = br_val;
    sel_mask[DEC_WT]  = wait_mask; sel_val[DEC_WT]  = wait_val;
    code[DEC_IRQ] = ctl_bits[5:4];
    code[DEC_BR]  = ctl_bits[3:2];
    code[DEC_WT]  = ctl_bits[1:0];
  end

  // One compare and one decode per decision, all on the same status sample
  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    dbc_match #(.STAT_W(STAT_W)) i_match (
      .status (dev_status),
      .mask   (sel_mask[g]),
      .value  (sel_val[g]),
      .hit    (cond_hit[g])
    );
    dbc_decide i_decide (
      .code     (code[g]),
      .cond     (cond_hit[g]),
      .decision (dec[g])
    );
  end

  logic [PTR_W-1:0] ptr_calc;
  dbc_ptr_step #(.PTR_W(PTR_W), .DESC_BYTES(DESC_BYTES)) i_step (
    .cur_ptr (cur_ptr),
    .target  (cmd_dep),
    .take    (dec[DEC_BR]),
    .nxt     (ptr_calc)
  );

  // Next-state logic
  logic             irq_d, adv_d, wait_d, bt_d;
  logic             ptr_en;
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    adv_d  = eval_req & ~dec[DEC_WT];
    irq_d  = adv_d & dec[DEC_IRQ];
    wait_d = eval_req ? dec[DEC_WT] : wait_hold;
    ptr_en = adv_d;
    ptr_d  = ptr_calc;
    bt_d   = dec[DEC_BR];
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse <= 1'b0;
      advance   <= 1'b0;
      wait_hold <= 1'b0;
    end else begin
      irq_pulse <= irq_d;
      advance   <= adv_d;
      wait_hold <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_ptr     <= '0;
      branch_taken <= 1'b0;
    end else if (ptr_en) begin
      next_ptr     <= ptr_d;
      branch_taken <= bt_d;
    end
  end

  // Assertions
  assert_irq_needs_eval_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_req |=> !irq_pulse);
  assert_irq_implies_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> advance);
  assert_adv_excludes_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !wait_hold);
  assert_adv_needs_eval_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_req |=> !advance);
  assert_ptr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |-> $stable(next_ptr) && $stable(branch_taken));
  assert_branch_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eval_req |=> (advance && branch_taken) -> (next_ptr == $past(cmd_dep)));
  assert_seq_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eval_req |=> (advance && !branch_taken) -> (next_ptr == $past(cur_ptr) + STEP));
  assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_req |=> $stable(wait_hold));
endmodule

// File: tb/test_dbc_eval_top.sv
module test_dbc_eval_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        eval_req;
  logic [5:0]  ctl_bits;
  logic [3:0]  dev_status, int_mask, int_val, br_mask, br_val, wait_mask, wait_val;
  logic [31:0] cur_ptr, cmd_dep;
  logic        irq_pulse, advance, wait_hold, branch_taken;
  logic [31:0] next_ptr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbc_eval_top i_dbc_eval_top (
    .clk(clk), .rst_n(rst_n), .eval_req(eval_req), .ctl_bits(ctl_bits),
    .dev_status(dev_status), .int_mask(int_mask), .int_val(int_val),
    .br_mask(br_mask), .br_val(br_val), .wait_mask(wait_mask), .wait_val(wait_val),
    .cur_ptr(cur_ptr), .cmd_dep(cmd_dep), .irq_pulse(irq_pulse), .advance(advance),
    .wait_hold(wait_hold), .next_ptr(next_ptr), .branch_taken(branch_taken)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_cond(input logic [3:0] s, input logic [3:0] m, input logic [3:0] v);
    return (s & m) == (v & m);
  endfunction

  function automatic bit ref_dec(input logic [1:0] c, input bit cond);
    case (c)
      2'd0: return 1'b0;
      2'd1: return cond;
      2'd2: return !cond;
      default: return 1'b1;
    endcase
  endfunction

  // Pulse eval_req for one cycle, then check all outputs at the following negedge
  task automatic eval_and_check(input string req, input logic [5:0] ctl, input logic [3:0] st,
                                input logic [31:0] cp, input logic [31:0] dep);
    bit c_i, c_b, c_w, d_i, d_b, d_w;
    logic [31:0] prev_ptr;
    logic prev_bt;
    prev_ptr = next_ptr;
    prev_bt  = branch_taken;
    c_i = ref_cond(st, int_mask, int_val);
    c_b = ref_cond(st, br_mask, br_val);
    c_w = ref_cond(st, wait_mask, wait_val);
    d_i = ref_dec(ctl[5:4], c_i);
    d_b = ref_dec(ctl[3:2], c_b);
    d_w = ref_dec(ctl[1:0], c_w);
    ctl_bits = ctl; dev_status = st; cur_ptr = cp; cmd_dep = dep;
    eval_req = 1'b1;
    @(negedge clk);
    eval_req = 1'b0;
    chk(req, "wait_hold", {31'd0, wait_hold}, {31'd0, d_w});
    chk(req, "advance", {31'd0, advance}, {31'd0, !d_w});
    chk(req, "irq_pulse", {31'd0, irq_pulse}, {31'd0, !d_w && d_i});
    if (d_w) begin
      chk(req, "next_ptr held", next_ptr, prev_ptr);
      chk(req, "branch_taken held", {31'd0, branch_taken}, {31'd0, prev_bt});
    end else begin
      chk(req, "next_ptr", next_ptr, d_b ? dep : cp + 32'd16);
      chk(req, "branch_taken", {31'd0, branch_taken}, {31'd0, d_b});
    end
    @(negedge clk);
    chk("R8", "irq one cycle", {31'd0, irq_pulse}, 32'd0);
    chk("R8", "advance one cycle", {31'd0, advance}, 32'd0);
  endtask

  task automatic set_sel(input logic [3:0] im, iv, bm, bv, wm, wv);
    int_mask = im; int_val = iv; br_mask = bm; br_val = bv; wait_mask = wm; wait_val = wv;
  endtask

  task automatic t_reset;
    chk("R1", "irq_pulse", {31'd0, irq_pulse}, 32'd0);
    chk("R1", "advance", {31'd0, advance}, 32'd0);
    chk("R1", "wait_hold", {31'd0, wait_hold}, 32'd0);
    chk("R1", "branch_taken", {31'd0, branch_taken}, 32'd0);
    chk("R1", "next_ptr", next_ptr, 32'd0);
  endtask

  task automatic t_irq_codes;
    set_sel(4'hF, 4'h5, 4'h0, 4'h0, 4'h0, 4'h0);
    for (int c = 0; c < 4; c++) begin
      eval_and_check("R3", {c[1:0], 4'b0000}, 4'h5, 32'h100, 32'h0);
      eval_and_check("R3", {c[1:0], 4'b0000}, 4'h4, 32'h200, 32'h0);
    end
  endtask

  task automatic t_branch_codes;
    set_sel(4'h0, 4'h0, 4'h3, 4'h2, 4'h0, 4'h0);
    for (int c = 0; c < 4; c++) begin
      eval_and_check("R4", {2'b00, c[1:0], 2'b00}, 4'hE, 32'h1000, 32'hABCD0000);
      eval_and_check("R5", {2'b00, c[1:0], 2'b00}, 4'hF, 32'h2000, 32'h55550000);
    end
    eval_and_check("R5", 6'b000000, 4'h0, 32'hFFFFFFF0, 32'h0);
    chk("R5", "wrap", next_ptr, 32'h0);
  endtask

  task automatic t_mask;
    set_sel(4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0);
    eval_and_check("R2", 6'b010000, 4'h3, 32'h40, 32'h0);
    chk("R2", "zero mask true", {31'd0, irq_pulse}, 32'd0);
    set_sel(4'h8, 4'h8, 4'h0, 4'h0, 4'h0, 4'h0);
    eval_and_check("R2", 6'b010000, 4'h8, 32'h40, 32'h0);
    eval_and_check("R2", 6'b010000, 4'h7, 32'h40, 32'h0);
  endtask

  task automatic t_wait;
    set_sel(4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h1);
    eval_and_check("R6", 6'b001100, 4'h0, 32'h300, 32'h900);
    eval_and_check("R6", 6'b111101, 4'h1, 32'h310, 32'h990);
    eval_and_check("R6", 6'b111110, 4'h0, 32'h320, 32'h990);
    eval_and_check("R6", 6'b110011, 4'h0, 32'h330, 32'h990);
    eval_and_check("R8", 6'b000010, 4'h1, 32'h340, 32'h990);
  endtask

  task automatic t_sample;
    logic [31:0] p;
    set_sel(4'hF, 4'h9, 4'hF, 4'h9, 4'hF, 4'h6);
    eval_and_check("R7", 6'b010101, 4'h9, 32'h500, 32'h700);
    p = next_ptr;
    dev_status = 4'h6; cur_ptr = 32'hDEAD0000; cmd_dep = 32'hBEEF0000; ctl_bits = 6'b111111;
    repeat (3) @(negedge clk);
    chk("R7", "ptr unaffected", next_ptr, p);
    chk("R7", "wait unaffected", {31'd0, wait_hold}, 32'd0);
    chk("R7", "irq unaffected", {31'd0, irq_pulse}, 32'd0);
    chk("R7", "bt unaffected", {31'd0, branch_taken}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; eval_req = 1'b0; ctl_bits = '0; dev_status = '0;
    set_sel(4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0);
    cur_ptr = '0; cmd_dep = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq_codes();
    t_branch_codes();
    t_mask();
    t_wait();
    t_sample();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule